// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of the two-wire serial management bus used to reach Ethernet PHY registers. Each request runs one complete register access. The host pulses a start strobe and gives a direction bit, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The block builds the whole frame on the management clock and data lines, then returns a one-cycle completion pulse, an error bit and, for reads, the 16-bit register value.

The management clock is made from the system clock. Each half-period lasts `HALF_DIV` system clocks. The data line leaves the block as a value plus an output-enable, which feed an external tristate pad with a pull-up. The returning line passes through a two-stage synchronizer before it is sampled. `HALF_DIV` must be at least 3, so that the synchronized value settles inside the high half-period in which it is sampled.

On a read, the block checks that the PHY pulls the line low in the first turnaround slot. If the PHY does not, the block runs a fixed train of released recovery clocks, then finishes with the error bit set and returns zero data. Every good frame ends with one released clock after the data field.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous reset, and whenever no access is in progress, `mdc_o` is low, `mdio_oe_o` is low, and `busy_o`, `done_o` and `err_o` are low.
- R2: Each frame opens with 32 clock slots with the data line driven high.
- R3: After the opening ones, the line carries the start pair 0,1 and then an operation pair: 1,0 for a read (`rd_i`=1) and 0,1 for a write (`rd_i`=0).
- R4: Next come the PHY address and then the register address, each 5 bits wide and sent most significant bit first.
- R5: Each slot lasts 2*`HALF_DIV` system clocks: the low half comes first and the rising edge falls in the middle. The driven data value changes only while `mdc_o` is low.
- R6: A write drives the turnaround pair 1,0 and then the 16 data bits, most significant first. It then releases the line for one further slot, so the frame has 65 rising edges in total before `done_o`.
- R7: A read releases the line from slot 47 onward. It samples slot 47 as the turnaround bit and slots 48 to 63 as data bits 15 down to 0, each at the end of the high half. After one released tail slot (64 rising edges in total), it pulses `done_o` with `err_o`=0 and `rdata_o` holding the value it captured.
- R8: If the line is not low in the sampled turnaround slot, the block issues 32 more released slots (79 rising edges in total). It then pulses `done_o` with `err_o`=1 and `rdata_o`=0.
- R9: `busy_o` rises on the cycle after an accepted start and falls on the cycle in which `done_o` pulses. `done_o` lasts one cycle. A start strobe while `busy_o` is high is ignored, and changes to the request inputs during a frame do not alter it.
- R10: `err_o` and `rdata_o` keep their values from the completion pulse until the next start is accepted. An accepted start clears `err_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| rd_i | input | 1 | 1 = register read, 0 = register write |
| phy_i | input | 5 | PHY address |
| reg_i | input | 5 | Register address |
| wdata_i | input | 16 | Value to write |
| rdata_o | output | 16 | Value read, valid from the completion pulse |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Turnaround failure on the last read |
| busy_o | output | 1 | An access is in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data value toward the pad |
| mdio_oe_o | output | 1 | Pad output-enable, 1 = drive |
| mdio_i | input | 1 | Data line as seen at the pad |

## Verification
The assertions assume that `rst` is held for at least one clock edge. They also assume that `mdio_i` is a plain level that may change at any time, since it is synchronized before use. They make no demands on the timing of `start_i`, which the bench deliberately pulses in the middle of a frame. The bench's PHY model changes the line only on falling management-clock edges and releases it, leaving it to the pull-up, outside the slots it owns. The requests use distinct address and data patterns, so a swapped or shifted field is detected.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_HDR,
    S_WDAT,
    S_TA,
    S_RDAT,
    S_RCV,
    S_TAIL
  } mst_state_e;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] TA_WRITE  = 2'b10;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RESET_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdio_halftimer.sv
module mdio_halftimer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_DIV - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i)   cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  // R5: half-periods of at least two clocks never produce back-to-back ticks
  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    (tick_o && run_i) |=> !tick_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PRE_LEN  = 32,
  parameter int RCV_LEN  = 32,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int HDR_N = 4 + 2 * ADDR_W;
  localparam int WR_N  = 2 + DATA_W;
  localparam int TX_W  = HDR_N + WR_N;
  localparam int CW    = $clog2(PRE_LEN + RCV_LEN + WR_N + HDR_N);

  mst_state_e        st_q;
  logic [CW-1:0]     cnt_q;
  logic [TX_W-1:0]   tx_q;
  logic [DATA_W-1:0] rx_q;
  logic              rd_q;
  logic              tick;
  logic              mdi_s;

  mdio_halftimer #(.HALF_DIV(HALF_DIV)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .run_i  (st_q != S_IDLE),
    .tick_o (tick)
  );

  mdio_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (mdio_i),
    .q_o (mdi_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      rd_q      <= 1'b0;
      rdata_o   <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      busy_o    <= 1'b0;
      mdc_o     <= 1'b0;
      mdio_o    <= 1'b0;
      mdio_oe_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st_q == S_IDLE) begin
        if (start_i) begin
          st_q      <= S_PRE;
          cnt_q     <= CW'(PRE_LEN - 1);
          tx_q      <= {START_PAT, (rd_i ? OP_READ : OP_WRITE), phy_i, reg_i,
                        TA_WRITE, wdata_i};
          rd_q      <= rd_i;
          busy_o    <= 1'b1;
          err_o     <= 1'b0;
          mdc_o     <= 1'b0;
          mdio_o    <= 1'b1;
          mdio_oe_o <= 1'b1;
        end
      end else if (tick) begin
        if (!mdc_o) begin
          mdc_o <= 1'b1;
        end else begin
          mdc_o <= 1'b0;
          case (st_q)
            S_PRE: begin
              if (cnt_q == '0) begin
                st_q   <= S_HDR;
                cnt_q  <= CW'(HDR_N - 1);
                mdio_o <= tx_q[TX_W-1];
                tx_q   <= tx_q << 1;
              end else cnt_q <= cnt_q - 1'b1;
            end
            S_HDR: begin
              if (cnt_q == '0) begin
                if (rd_q) begin
                  st_q      <= S_TA;
                  mdio_oe_o <= 1'b0;
                end else begin
                  st_q   <= S_WDAT;
                  cnt_q  <= CW'(WR_N - 1);
                  mdio_o <= tx_q[TX_W-1];
                  tx_q   <= tx_q << 1;
                end
              end else begin
                cnt_q  <= cnt_q - 1'b1;
                mdio_o <= tx_q[TX_W-1];
                tx_q   <= tx_q << 1;
              end
            end
            S_WDAT: begin
              if (cnt_q == '0) begin
                st_q      <= S_TAIL;
                mdio_oe_o <= 1'b0;
              end else begin
                cnt_q  <= cnt_q - 1'b1;
                mdio_o <= tx_q[TX_W-1];
                tx_q   <= tx_q << 1;
              end
            end
            S_TA: begin
              if (mdi_s) begin
                st_q  <= S_RCV;
                cnt_q <= CW'(RCV_LEN - 1);
              end else begin
                st_q  <= S_RDAT;
                cnt_q <= CW'(DATA_W - 1);
              end
            end
            S_RDAT: begin
              rx_q <= {rx_q[DATA_W-2:0], mdi_s};
              if (cnt_q == '0) st_q <= S_TAIL;
              else             cnt_q <= cnt_q - 1'b1;
            end
            S_RCV: begin
              if (cnt_q == '0) begin
                st_q    <= S_IDLE;
                busy_o  <= 1'b0;
                done_o  <= 1'b1;
                err_o   <= 1'b1;
                rdata_o <= '0;
              end else cnt_q <= cnt_q - 1'b1;
            end
            S_TAIL: begin
              st_q   <= S_IDLE;
              busy_o <= 1'b0;
              done_o <= 1'b1;
              if (rd_q) rdata_o <= rx_q;
            end
            default: st_q <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R1: outside an access the clock rests low and the pad is released
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  // R5: a new data value never appears while the clock is high
  p_data_low_phase_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !$stable(mdio_o)) |-> !mdc_o);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: busy only drops together with completion
  p_busy_until_done_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R10: error flag moves only on completion or on an accepted start
  p_err_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(err_o) |-> (done_o || busy_o));

  // R10: read value moves only on completion
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata_o) |-> done_o);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [4:0]  phy_i = '0;
  logic [4:0]  reg_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        done_o, err_o, busy_o, mdc_o, mdio_o, mdio_oe_o;

  logic        phy_en = 1'b0;
  logic        phy_val = 1'b1;
  int          phy_mode = 0;
  logic [15:0] phy_data = '0;
  wire         line = mdio_oe_o ? mdio_o : (phy_en ? phy_val : 1'b1);

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .rd_i(rd_i), .phy_i(phy_i),
    .reg_i(reg_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o),
    .err_o(err_o), .busy_o(busy_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .mdio_i(line)
  );

  // Line monitor: bits seen on each rising management clock edge
  int   rises = 0;
  logic lb [0:127];
  logic oeb [0:127];
  int   clk_n = 0;
  int   last_rise = 0;
  int   bad_period = 0;
  int   bad_phase = 0;
  int   dones = 0;
  logic prev_mdo = 1'b0;

  always @(posedge clk) begin
    clk_n <= clk_n + 1;
    if (done_o) dones <= dones + 1;
  end

  always @(posedge mdc_o) begin
    if (rises > 0 && (clk_n - last_rise) != 2 * HALF) bad_period++;
    last_rise = clk_n;
    rises++;
    if (rises < 128) begin
      lb[rises]  = line;
      oeb[rises] = mdio_oe_o;
    end
  end

  always @(negedge clk) begin
    if (busy_o && mdio_oe_o && (mdio_o !== prev_mdo) && mdc_o) bad_phase++;
    prev_mdo = mdio_o;
  end

  // PHY model: changes the line only after falling clock edges
  always @(negedge mdc_o) begin
    if (phy_mode == 1) begin
      if (rises == 46) begin
        phy_en  = 1'b1;
        phy_val = 1'b0;
      end else if (rises >= 47 && rises <= 62) begin
        phy_val = phy_data[62 - rises];
      end else if (rises == 63) begin
        phy_en = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd);
    @(negedge clk);
    rises = 0; bad_period = 0; bad_phase = 0; dones = 0;
    rd_i = rd; phy_i = pa; reg_i = ra; wdata_i = wd;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      if (done_o) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_header(input logic rd, input logic [4:0] pa, input logic [4:0] ra);
    logic [13:0] hdr;
    int bad_pre = 0;
    int bad_hdr = 0;
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
    for (int k = 1; k <= 32; k++) if (lb[k] !== 1'b1 || oeb[k] !== 1'b1) bad_pre++;
    chk(bad_pre == 0, "R2 preamble ones", 64'(bad_pre), 64'd0);
    for (int k = 33; k <= 36; k++) if (lb[k] !== hdr[13 - (k - 33)]) bad_hdr++;
    chk(bad_hdr == 0, "R3 start and opcode", 64'(bad_hdr), 64'd0);
    bad_hdr = 0;
    for (int k = 37; k <= 46; k++) if (lb[k] !== hdr[13 - (k - 33)]) bad_hdr++;
    chk(bad_hdr == 0, "R4 phy and register address", 64'(bad_hdr), 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mdc_o == 0 && mdio_oe_o == 0, "R1 reset pad idle", {mdc_o, mdio_oe_o}, 0);
    chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1 reset flags",
        {busy_o, done_o, err_o}, 0);
  endtask

  task automatic t_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    bit ok;
    logic [17:0] tail;
    int bad = 0;
    launch(1'b0, pa, ra, wd);
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    wait_done(ok);
    chk(ok, "R6 write completes", ok, 1);
    chk(busy_o == 1'b0, "R9 busy low with done", busy_o, 0);
    check_header(1'b0, pa, ra);
    tail = {2'b10, wd};
    for (int k = 47; k <= 64; k++) if (lb[k] !== tail[17 - (k - 47)] || oeb[k] !== 1'b1) bad++;
    chk(bad == 0, "R6 turnaround and data", 64'(bad), 0);
    chk(oeb[65] === 1'b0, "R6 released tail slot", oeb[65], 0);
    chk(rises == 65, "R6 rising edge count", rises, 65);
    chk(err_o == 1'b0, "R6 no error on write", err_o, 0);
    chk(bad_period == 0, "R5 slot period", bad_period, 0);
    chk(bad_phase == 0, "R5 data change while low", bad_phase, 0);
    @(negedge clk);
    chk(mdc_o == 0 && mdio_oe_o == 0 && busy_o == 0, "R1 idle after write",
        {mdc_o, mdio_oe_o, busy_o}, 0);
  endtask

  task automatic t_read_ok(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] val);
    bit ok;
    int bad = 0;
    phy_mode = 1; phy_data = val;
    launch(1'b1, pa, ra, 16'h0);
    wait_done(ok);
    chk(ok, "R7 read completes", ok, 1);
    check_header(1'b1, pa, ra);
    for (int k = 47; k <= 64; k++) if (oeb[k] !== 1'b0) bad++;
    chk(bad == 0, "R7 line released", 64'(bad), 0);
    chk(rises == 64, "R7 rising edge count", rises, 64);
    chk(rdata_o == val, "R7 read value", rdata_o, val);
    chk(err_o == 1'b0, "R7 no error", err_o, 0);
    chk(bad_period == 0, "R5 slot period on read", bad_period, 0);
    phy_mode = 0; phy_en = 1'b0;
  endtask

  task automatic t_read_noack();
    bit ok;
    int bad = 0;
    phy_mode = 0; phy_en = 1'b0;
    launch(1'b1, 5'h11, 5'h02, 16'h0);
    wait_done(ok);
    chk(ok, "R8 failed read completes", ok, 1);
    chk(rises == 79, "R8 recovery edge count", rises, 79);
    for (int k = 47; k <= 79; k++) if (oeb[k] !== 1'b0) bad++;
    chk(bad == 0, "R8 released during recovery", 64'(bad), 0);
    chk(err_o == 1'b1, "R8 error flag", err_o, 1);
    chk(rdata_o == 16'h0, "R8 zero data", rdata_o, 0);
  endtask

  task automatic t_hold();
    repeat (60) @(negedge clk);
    chk(err_o == 1'b1 && rdata_o == 16'h0, "R10 flags held after done",
        {err_o, rdata_o}, {1'b1, 16'h0});
    launch(1'b0, 5'h01, 5'h01, 16'h1);
    chk(err_o == 1'b0, "R10 error cleared on start", err_o, 0);
    begin bit ok; wait_done(ok); end
  endtask

  task automatic t_busy_ignore();
    bit ok;
    launch(1'b0, 5'h0A, 5'h15, 16'hC3A5);
    repeat (100) @(negedge clk);
    chk(busy_o == 1'b1, "R9 busy mid frame", busy_o, 1);
    rd_i = 1'b1; phy_i = 5'h1F; reg_i = 5'h00; wdata_i = 16'h0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(ok);
    @(negedge clk);
    check_header(1'b0, 5'h0A, 5'h15);
    chk(rises == 65, "R9 frame unchanged by extra start", rises, 65);
    repeat (600) @(negedge clk);
    chk(dones == 1 && busy_o == 0, "R9 single completion", dones, 1);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write(5'h15, 5'h0A, 16'hA55A);
    t_write(5'h01, 5'h1E, 16'h8001);
    t_read_ok(5'h03, 5'h11, 16'h3C96);
    t_read_ok(5'h1C, 5'h05, 16'hFFFE);
    t_read_noack();
    t_hold();
    t_busy_ignore();
    t_read_ok(5'h07, 5'h19, 16'h0001);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule